// File: doc/BRIEF.md
# CSR Acknowledge Error Checker

This block sits beside a bus commander and watches the CSR commands it issues. It expects a command acknowledge within a fixed number of cycles. If none arrives, it records a sticky no-acknowledge error. The response to that error depends on the kind of command:

- A write to an ordinary register is fatal and also raises a nonexistent-write flag.
- A write that falls in the mailbox address range only records the no-acknowledge error.
- A read completes with substitute data of all ones and a one-cycle fill-error strobe.

The block also compares the acknowledge value this node drives against the value seen on the line. Any difference is a transmit check error. It is system fatal and raises the fault output.

The error bits sit in an 8-bit status vector. Bit 0 is the nonexistent-write flag, bit 4 is no-acknowledge and bit 6 is the acknowledge transmit check error. Each bit is cleared by writing a one to it.

When the I/O-port variant is built (`IO_PORT=1`), two extra behaviours apply:

- A transmit check error raised while this node has a command outstanding also sets the no-acknowledge bit.
- A set no-acknowledge bit drives an interrupt request while interrupts are enabled.

Top module: `csr_ack_checker`

## Requirements
- R1: After a synchronous reset, `err_bits`, `rd_valid`, `fill_err`, `fault`, `fatal` and `irq` are all 0.
- R2: A command is accepted on a clock edge where `cmd_valid` is high and no command is outstanding. If `ack_obs` is high at any of the ACK_WIN edges after that edge, no error bit is set and no substitute read is produced.
- R3: If `ack_obs` stays low through edge ACK_WIN after the command edge, `err_bits[4]` reads 1 right after that edge.
- R4: A timed-out write outside the mailbox range also sets `err_bits[0]`, and `fatal` goes high in the same cycle.
- R5: A timed-out write to an address in [MBX_LO, MBX_HI] sets only `err_bits[4]`. `err_bits[0]` and `fatal` stay 0.
- R6: A timed-out read raises `rd_valid` and `fill_err` for exactly one cycle. During that cycle `rd_data` is all ones, and `err_bits[4]` becomes 1 in the same cycle.
- R7: On an edge where `ack_drv_en` is high and `ack_drv` differs from `ack_obs`, `err_bits[6]` is set. From the next cycle `fault` and `fatal` are high.
- R8: In the I/O-port variant, such a mismatch on an edge while a command is outstanding also sets `err_bits[4]`. A mismatch with no command outstanding does not set it.
- R9: In the I/O-port variant, `irq` equals `irq_en` AND `err_bits[4]`.
- R10: An edge with `clr_valid` high clears each error bit whose `clr_mask` bit is 1 and leaves the other bits unchanged.
- R11: If an error sets a bit on the same edge that `clr_mask` clears it, the bit ends up set.
- R12: While a command is outstanding, `cmd_valid` is ignored. The outstanding command keeps its type and its original deadline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A CSR command is issued this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | CSR address of the command |
| ack_obs | input | 1 | Acknowledge line as observed |
| ack_drv_en | input | 1 | This node is driving the acknowledge line |
| ack_drv | input | 1 | Value this node drives on the acknowledge line |
| clr_valid | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | ERR_W | Bits to clear |
| irq_en | input | 1 | Interrupt enable (I/O-port variant) |
| err_bits | output | ERR_W | Sticky error status |
| fault | output | 1 | Transmit check fault |
| fatal | output | 1 | Any fatal error recorded |
| irq | output | 1 | Interrupt request |
| rd_valid | output | 1 | Substitute read data valid |
| rd_data | output | DATA_W | Substitute read data |
| fill_err | output | 1 | Fill-error strobe |

## Verification
The bench builds the block with:

| Parameter | Value |
|---|---|
| `ACK_WIN` | 4 |
| `IO_PORT` | 1 |
| `ADDR_W` | 8 |
| mailbox range | 0xF0 to 0xF7 |

The short window means every acknowledge delay can be tried within a few cycles, from the first edge through the deadline edge to no acknowledge at all. The I/O-port variant brings the interrupt path and the commander-side transmit check path into reach. The narrow mailbox range, drawn often by the random address picker, lets a single run cover the three timeout responses and the range boundaries.

// File: rtl/csr_ack_pkg.sv
package csr_ack_pkg;

    localparam int ERR_W_DEF = 8;
    localparam int BIT_NXM   = 0;
    localparam int BIT_NAE   = 4;
    localparam int BIT_TCE   = 6;

    typedef enum logic [1:0] {
        CK_READ   = 2'd0,
        CK_WR_REG = 2'd1,
        CK_WR_MBX = 2'd2
    } cmd_kind_e;

    function automatic cmd_kind_e classify(input logic is_write, input logic in_mbx);
        if (!is_write)  return CK_READ;
        else if (in_mbx) return CK_WR_MBX;
        else             return CK_WR_REG;
    endfunction

endpackage

// File: rtl/csr_ack_timer.sv
module csr_ack_timer
    import csr_ack_pkg::*;
#(
    parameter int          ACK_WIN = 8,
    parameter int          ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] MBX_LO = '0,
    parameter logic [ADDR_W-1:0] MBX_HI = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              ack_seen,
    output logic              pending,
    output logic              expire,
    output cmd_kind_e         kind
);
    localparam int CNT_W = $clog2(ACK_WIN + 1);
    localparam logic [CNT_W-1:0] WIN_C = CNT_W'(ACK_WIN);

    logic [CNT_W-1:0] cnt;
    logic             in_mbx;

    assign in_mbx = (cmd_addr >= MBX_LO) && (cmd_addr <= MBX_HI);
    assign expire = pending && !ack_seen && (cnt == WIN_C);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            cnt     <= '0;
            kind    <= CK_READ;
        end else if (!pending) begin
            if (cmd_valid) begin
                pending <= 1'b1;
                cnt     <= CNT_W'(1);
                kind    <= classify(cmd_write, in_mbx);
            end
        end else if (ack_seen || cnt == WIN_C) begin
            pending <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R12: an outstanding command keeps counting toward its own deadline
    a_r12_keeps_counting: assert property (@(posedge clk) disable iff (rst)
        pending && !ack_seen && cnt != WIN_C |=> pending && cnt == $past(cnt) + 1'b1);

    // R12: the command type is frozen while outstanding
    a_r12_kind_frozen: assert property (@(posedge clk) disable iff (rst)
        pending && !expire && !ack_seen |=> $stable(kind));

    // R3: the count never passes the window
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        pending |-> cnt <= WIN_C && cnt != '0);

endmodule

// File: rtl/csr_err_status.sv
module csr_err_status
    import csr_ack_pkg::*;
#(
    parameter int ERR_W   = ERR_W_DEF,
    parameter bit IO_PORT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             expire,
    input  cmd_kind_e        kind,
    input  logic             pending,
    input  logic             tce,
    input  logic             clr_valid,
    input  logic [ERR_W-1:0] clr_mask,
    output logic [ERR_W-1:0] err
);
    logic [ERR_W-1:0] set_vec;
    logic [ERR_W-1:0] clr_vec;

    always_comb begin
        set_vec          = '0;
        set_vec[BIT_NAE] = expire || (IO_PORT && tce && pending);
        set_vec[BIT_NXM] = expire && (kind == CK_WR_REG);
        set_vec[BIT_TCE] = tce;
        clr_vec          = clr_valid ? clr_mask : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) err <= '0;
        else     err <= (err & ~clr_vec) | set_vec;
    end

    // R11: any bit set by an error on an edge is 1 afterwards, clear or not
    a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_vec != '0 |=> (err & $past(set_vec)) == $past(set_vec));

    // R7: a transmit mismatch always lands in the status
    a_r7_tce_sticks: assert property (@(posedge clk) disable iff (rst)
        tce |=> err[BIT_TCE]);

    // R10: without set or clear, status holds
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        set_vec == '0 && clr_vec == '0 |=> $stable(err));

endmodule

// File: rtl/csr_rd_sub.sv
module csr_rd_sub
    import csr_ack_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              expire,
    input  cmd_kind_e         kind,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              fill_err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            fill_err <= 1'b0;
        end else begin
            rd_valid <= expire && (kind == CK_READ);
            fill_err <= expire && (kind == CK_READ);
        end
    end

    assign rd_data = rd_valid ? '1 : '0;

    // R6: a timed-out read produces the substitute beat on the next cycle
    a_r6_read_sub: assert property (@(posedge clk) disable iff (rst)
        expire && kind == CK_READ |=> rd_valid && fill_err);

    // R6: the fill-error strobe lasts one cycle
    a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
        fill_err |=> !fill_err);

endmodule

// File: rtl/csr_ack_checker.sv
module csr_ack_checker
    import csr_ack_pkg::*;
#(
    parameter int                ACK_WIN = 8,
    parameter int                ADDR_W  = 8,
    parameter int                DATA_W  = 32,
    parameter int                ERR_W   = ERR_W_DEF,
    parameter logic [ADDR_W-1:0] MBX_LO  = 8'hF0,
    parameter logic [ADDR_W-1:0] MBX_HI  = 8'hF7,
    parameter bit                IO_PORT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              ack_obs,
    input  logic              ack_drv_en,
    input  logic              ack_drv,
    input  logic              clr_valid,
    input  logic [ERR_W-1:0]  clr_mask,
    input  logic              irq_en,
    output logic [ERR_W-1:0]  err_bits,
    output logic              fault,
    output logic              fatal,
    output logic              irq,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              fill_err
);
    logic      pending;
    logic      expire;
    logic      tce;
    cmd_kind_e kind;

    assign tce = ack_drv_en && (ack_drv != ack_obs);

    csr_ack_timer #(
        .ACK_WIN(ACK_WIN), .ADDR_W(ADDR_W), .MBX_LO(MBX_LO), .MBX_HI(MBX_HI)
    ) u_timer (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .ack_seen(ack_obs), .pending(pending),
        .expire(expire), .kind(kind)
    );

    csr_err_status #(.ERR_W(ERR_W), .IO_PORT(IO_PORT)) u_status (
        .clk(clk), .rst(rst), .expire(expire), .kind(kind), .pending(pending),
        .tce(tce), .clr_valid(clr_valid), .clr_mask(clr_mask), .err(err_bits)
    );

    csr_rd_sub #(.DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst(rst), .expire(expire), .kind(kind),
        .rd_valid(rd_valid), .rd_data(rd_data), .fill_err(fill_err)
    );

    assign fault = err_bits[BIT_TCE];
    assign fatal = err_bits[BIT_TCE] | err_bits[BIT_NXM];

    generate
        if (IO_PORT) begin : g_irq
            assign irq = irq_en & err_bits[BIT_NAE];
        end else begin : g_noirq
            assign irq = 1'b0;
        end
    endgenerate

    // R4: a timed-out ordinary write is fatal in the next cycle
    a_r4_wr_fatal: assert property (@(posedge clk) disable iff (rst)
        expire && kind == CK_WR_REG |=> fatal && err_bits[BIT_NXM]);

    // R3: every timeout records no-acknowledge
    a_r3_nae_set: assert property (@(posedge clk) disable iff (rst)
        expire |=> err_bits[BIT_NAE]);

endmodule

// File: tb/tb_csr_ack_checker.sv
module tb_csr_ack_checker;
    localparam int WIN    = 4;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int ERR_W  = 8;
    localparam logic [7:0] MLO = 8'hF0;
    localparam logic [7:0] MHI = 8'hF7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 0, cmd_write = 0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic ack_obs = 0, ack_drv_en = 0, ack_drv = 0;
    logic clr_valid = 0;
    logic [ERR_W-1:0] clr_mask = '0;
    logic irq_en = 0;
    logic [ERR_W-1:0] err_bits;
    logic fault, fatal, irq, rd_valid, fill_err;
    logic [DATA_W-1:0] rd_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    csr_ack_checker #(
        .ACK_WIN(WIN), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERR_W(ERR_W),
        .MBX_LO(MLO), .MBX_HI(MHI), .IO_PORT(1'b1)
    ) dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] exp_err(input logic wr, input logic [7:0] a, input int dly);
        logic [7:0] e = '0;
        if (dly == 0) begin
            e[4] = 1'b1;
            if (wr && !(a >= MLO && a <= MHI)) e[0] = 1'b1;
        end
        return e;
    endfunction

    task automatic clear_all();
        clr_valid = 1; clr_mask = '1;
        step();
        clr_valid = 0; clr_mask = '0;
    endtask

    // issue a command; dly 0 = no ack, else ack sampled on edge dly after command edge
    task automatic run_cmd(input logic wr, input logic [7:0] a, input int dly);
        logic [7:0] e;
        cmd_valid = 1; cmd_write = wr; cmd_addr = a;
        step();
        cmd_valid = 0;
        for (int k = 1; k <= WIN; k++) begin
            ack_obs = (k == dly);
            step();
            ack_obs = 0;
        end
        e = exp_err(wr, a, dly);
        chk("R2/R3 err_bits", 32'(err_bits), 32'(e));
        chk("R4/R5 fatal", 32'(fatal), 32'(e[0]));
        chk("R6 rd_valid", 32'(rd_valid), 32'(dly == 0 && !wr));
        chk("R6 fill_err", 32'(fill_err), 32'(dly == 0 && !wr));
        if (dly == 0 && !wr) chk("R6 rd_data", rd_data, 32'hFFFF_FFFF);
        step();
        chk("R6 one-cycle", 32'({rd_valid, fill_err}), 32'd0);
        clear_all();
        chk("R10 clear all", 32'(err_bits), 32'd0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1957));
        step(); step();
        rst = 0;
        // R1 reset state
        chk("R1 err_bits", 32'(err_bits), 0);
        chk("R1 outputs", 32'({fault, fatal, irq, rd_valid, fill_err}), 0);

        // directed timeouts and boundaries
        run_cmd(1, 8'h10, 0);          // R4 ordinary write
        run_cmd(1, MLO, 0);            // R5 mailbox low edge
        run_cmd(1, MHI, 0);            // R5 mailbox high edge
        run_cmd(1, MHI + 8'd1, 0);     // R4 just past mailbox
        run_cmd(0, 8'h20, 0);          // R6 read
        run_cmd(0, 8'h20, WIN);        // R2 ack on last edge
        run_cmd(1, 8'h10, 1);          // R2 ack on first edge

        // random mix
        for (int i = 0; i < 40; i++) begin
            logic wr = 1'($urandom_range(1, 0));
            logic [7:0] a = ($urandom_range(1, 0) == 1) ? 8'($urandom_range(8'hF8, 8'hEF))
                                                         : 8'($urandom_range(255, 0));
            int dly = $urandom_range(WIN, 0);
            run_cmd(wr, a, dly);
        end

        // R7 mismatch with no command outstanding
        ack_drv_en = 1; ack_drv = 1; ack_obs = 0;
        step();
        ack_drv_en = 0; ack_drv = 0;
        chk("R7 tce bit", 32'(err_bits), 32'h40);
        chk("R7 fault", 32'({fault, fatal}), 32'd3);
        chk("R8 no nae when idle", 32'(err_bits[4]), 0);

        // R11 mismatch again while clearing bit 6
        ack_drv_en = 1; ack_drv = 1; clr_valid = 1; clr_mask = 8'h40;
        step();
        ack_drv_en = 0; ack_drv = 0; clr_valid = 0; clr_mask = 0;
        chk("R11 set wins", 32'(err_bits), 32'h40);
        clear_all();

        // R8 mismatch while a read is outstanding
        cmd_valid = 1; cmd_write = 0; cmd_addr = 8'h33;
        step();
        cmd_valid = 0;
        ack_drv_en = 1; ack_drv = 1; ack_obs = 0;
        step();
        ack_drv_en = 0; ack_drv = 0;
        chk("R8 nae on commander tce", 32'(err_bits), 32'h50);
        // R9 interrupt follows enable and bit 4
        irq_en = 1; #1;
        chk("R9 irq on", 32'(irq), 1);
        irq_en = 0; #1;
        chk("R9 irq off", 32'(irq), 0);
        irq_en = 1;
        // R10 partial clear: bit 6 only
        clr_valid = 1; clr_mask = 8'h40;
        step();
        clr_valid = 0; clr_mask = 0;
        chk("R10 partial clear", 32'(err_bits), 32'h10);
        for (int k = 0; k < WIN; k++) step();
        clear_all();
        chk("R9 irq after clear", 32'(irq), 0);
        irq_en = 0;

        // R12 second command while read pending is ignored
        cmd_valid = 1; cmd_write = 0; cmd_addr = 8'h44;
        step();
        cmd_write = 1; cmd_addr = 8'h05;      // held: ignored while pending
        for (int k = 1; k <= WIN; k++) step();
        cmd_valid = 0;
        chk("R12 original deadline", 32'(err_bits), 32'h10);
        chk("R12 type kept", 32'({rd_valid, fill_err}), 32'd3);
        clear_all();

        // R11 timeout set coinciding with clear of bit 4
        cmd_valid = 1; cmd_write = 1; cmd_addr = MLO;
        step();
        cmd_valid = 0;
        for (int k = 1; k < WIN; k++) step();
        clr_valid = 1; clr_mask = 8'h10;
        step();
        clr_valid = 0; clr_mask = 0;
        chk("R11 timeout beats clear", 32'(err_bits), 32'h10);
        clear_all();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule